// File: doc/BRIEF.md
# ECC-Protected Byte-Writable Word Memory

This block is a synchronous on-chip word memory with 16-bit data words and two byte lanes. Every stored word has five Hamming check bits. A write puts a 21-bit codeword into the array. Every read decodes the stored codeword, corrects any single flipped bit in the returned data, and raises a correction flag. A corrected error is never written back to the array. The bad bit stays stored until the word is written again.

The control inputs are active low and follow the usual asynchronous-SRAM conventions:
- a chip select;
- an output enable;
- a write strobe;
- a separate enable for each byte lane.

Tri-state pins are replaced by drive indications:
- one per byte lane;
- one for the correction flag.

An undriven lane always reads zero. A write to a single lane is done as read-modify-write. The stored word is read and corrected, the new byte is merged in, and all check bits are computed again. The untouched byte therefore stays covered by a valid code.

A fault-injection input flips one chosen bit of one stored codeword, so that the correction path can be tested. A command is sampled on one rising clock edge, and its result appears on the outputs after the next rising edge. Commands can be issued on every cycle. The depth is set by an address-width parameter: 18 gives the full 256K words, and a smaller value is used for simulation.

Top module: `ecc_sram_core`

## Requirements
- R1: While reset is high, and in the cycle after it, both lane drive outputs, the flag drive output, the correction flag and the read data are all zero.
- R2: A full-word write (both lane enables low) followed by a read returns the written word. A command sampled at rising edge N shows on the outputs after edge N+1.
- R3: The high lane enable governs data bits 15..8 and the low lane enable governs bits 7..0. A read drives only the lanes whose enable is low. An undriven lane reads as zero, and the flag is driven whenever at least one lane is driven.
- R4: A write with one lane enable low changes only that lane of the stored word. The other lane keeps its value.
- R5: With chip select high, no write takes place and nothing is driven, whatever the other controls are.
- R6: A write (chip select, write strobe and at least one lane enable low) takes place whatever the output enable is. Nothing is driven for a write command.
- R7: A selected command with both lane enables high writes nothing and drives nothing. A read with output enable high drives nothing.
- R8: After any single bit of the 21-bit stored codeword is flipped, a read returns the originally written data with the flag at 1 and the flag driven. A clean word reads with the flag at 0.
- R9: A correction is not written back. Repeated reads of a faulty word keep flagging, and a full rewrite clears the flag.
- R10: A single-lane write to a word that holds one flipped bit keeps the other lane's corrected value. The word then reads clean.
- R11: Back-to-back commands to the same address on consecutive cycles see the latest write, including two single-lane writes in a row.
- R12: In a fault-injection cycle the bus controls are ignored, and nothing is written or driven. Bit index k selects codeword bit k for k in 0..20. An index of 21 or more leaves the word unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_sel_n | input | 1 | Chip select, active low |
| out_en_n | input | 1 | Output enable for reads, active low |
| wr_n | input | 1 | Write strobe, active low |
| hi_lane_n | input | 1 | Enable for data bits 15..8, active low |
| lo_lane_n | input | 1 | Enable for data bits 7..0, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | 16 | Write data |
| inj_en | input | 1 | Fault-injection cycle at addr |
| inj_pos | input | 5 | Codeword bit index to flip |
| rdata | output | 16 | Corrected read data, zero in undriven lanes |
| hi_drv | output | 1 | High lane would be driven |
| lo_drv | output | 1 | Low lane would be driven |
| corr_flag | output | 1 | Single-bit error was corrected on this read |
| corr_drv | output | 1 | Correction flag would be driven |

## Verification
A wrong stored codeword shows up at the ports two edges after the next read of that address. It appears as a wrong flag value, or as wrong data once two bits differ. A stale value in the write-to-read bypass shows only when an access follows a write to the same address on the very next cycle, so back-to-back same-address sequences are driven both directly and at random. A merge fault in the read-modify-write path surfaces on the following read as a wrong untouched lane, or as a flag that should have cleared.

// File: rtl/ecc_sram_pkg.sv
package ecc_sram_pkg;
  localparam int DATA_W = 16;
  localparam int LANES  = DATA_W / 8;

  function automatic int chk_bits(int dw);
    for (int r = 1; r < 16; r++)
      if ((1 << r) >= dw + r + 1) return r;
    return 16;
  endfunction

  localparam int CHK_W = chk_bits(DATA_W);
  localparam int CW_W  = DATA_W + CHK_W;
  localparam int POS_W = $clog2(CW_W);

  typedef logic [DATA_W-1:0] word_t;
  typedef logic [CW_W-1:0]   cw_t;
  typedef enum logic [1:0] {OP_IDLE, OP_READ, OP_WRITE, OP_FAULT} op_e;

  // Hamming position p (1-based) holds a check bit when p is a power of two.
  function automatic bit is_pow2(int p);
    return (p & (p - 1)) == 0;
  endfunction

  // Data bit index stored at a non-power-of-two position p.
  function automatic int data_idx(int p);
    int c;
    c = 0;
    for (int q = 1; q < p; q++)
      if (!is_pow2(q)) c++;
    return c;
  endfunction

  // Positions covered by check bit k.
  function automatic cw_t cover_mask(int k);
    cw_t m;
    m = '0;
    for (int p = 1; p <= CW_W; p++)
      if (((p >> k) & 1) == 1) m[p-1] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/ecc_sram_enc.sv
module ecc_sram_enc
  import ecc_sram_pkg::*;
(
  input  word_t data_i,
  output cw_t   code_o
);
  cw_t spread;

  for (genvar p = 1; p <= CW_W; p++) begin : g_pos
    if (is_pow2(p)) begin : g_chk
      assign spread[p-1] = 1'b0;
      assign code_o[p-1] = ^(spread & cover_mask($clog2(p)));
    end else begin : g_dat
      assign spread[p-1] = data_i[data_idx(p)];
      assign code_o[p-1] = spread[p-1];
    end
  end
endmodule

// File: rtl/ecc_sram_dec.sv
module ecc_sram_dec
  import ecc_sram_pkg::*;
(
  input  cw_t   code_i,
  output word_t data_o,
  output logic  err_o
);
  logic [CHK_W-1:0] syn;

  for (genvar k = 0; k < CHK_W; k++) begin : g_syn
    assign syn[k] = ^(code_i & cover_mask(k));
  end

  for (genvar p = 1; p <= CW_W; p++) begin : g_fix
    if (!is_pow2(p)) begin : g_dat
      assign data_o[data_idx(p)] = code_i[p-1] ^ (syn == CHK_W'(p));
    end
  end

  assign err_o = |syn;
endmodule

// File: rtl/ecc_sram_mem.sv
module ecc_sram_mem #(
  parameter int IDX_W  = 10,
  parameter int WORD_W = 21
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_word
);
  localparam int DEPTH = 1 << IDX_W;

  logic [WORD_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_idx] <= wr_word;
  end

  always_ff @(posedge clk) begin
    rd_word <= store[rd_idx];
  end
endmodule

// File: rtl/ecc_sram_core.sv
module ecc_sram_core
  import ecc_sram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chip_sel_n,
  input  logic              out_en_n,
  input  logic              wr_n,
  input  logic              hi_lane_n,
  input  logic              lo_lane_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  input  logic              inj_en,
  input  logic [4:0]        inj_pos,
  output logic [15:0]       rdata,
  output logic              hi_drv,
  output logic              lo_drv,
  output logic              corr_flag,
  output logic              corr_drv
);
  // Command decode (stage 0)
  logic [LANES-1:0] cur_lanes;
  op_e              cur_op;

  assign cur_lanes = {~hi_lane_n, ~lo_lane_n};

  always_comb begin
    cur_op = OP_IDLE;
    if (inj_en)                         cur_op = OP_FAULT;
    else if (chip_sel_n)                cur_op = OP_IDLE;
    else if (!wr_n && |cur_lanes)       cur_op = OP_WRITE;
    else if (wr_n && !out_en_n && |cur_lanes) cur_op = OP_READ;
  end

  // Stage 1 command registers
  op_e              s_op;
  logic [ADDR_W-1:0] s_idx;
  word_t            s_wdata;
  logic [LANES-1:0] s_lanes;
  logic [4:0]       s_pos;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_op    <= OP_IDLE;
      s_lanes <= '0;
    end else begin
      s_op    <= cur_op;
      s_lanes <= cur_lanes;
    end
    s_idx   <= addr;
    s_wdata <= wdata;
    s_pos   <= inj_pos;
  end

  // Array and same-address bypass
  cw_t  mem_q, cw_cur, wr_cw, enc_cw, fault_mask;
  cw_t  byp_word_q;
  logic byp_hit_q;
  logic wr_live;

  assign wr_live = (s_op == OP_WRITE) || (s_op == OP_FAULT);

  ecc_sram_mem #(.IDX_W(ADDR_W), .WORD_W(CW_W)) mem_i (
    .clk     (clk),
    .wr_en   (wr_live),
    .wr_idx  (s_idx),
    .wr_word (wr_cw),
    .rd_idx  (addr),
    .rd_word (mem_q)
  );

  always_ff @(posedge clk) begin
    if (rst) byp_hit_q <= 1'b0;
    else     byp_hit_q <= wr_live && (s_idx == addr);
    byp_word_q <= wr_cw;
  end

  assign cw_cur = byp_hit_q ? byp_word_q : mem_q;

  // Correction, merge and re-encode
  word_t corr_word, merged;
  logic  syn_nz;

  ecc_sram_dec dec_i (
    .code_i (cw_cur),
    .data_o (corr_word),
    .err_o  (syn_nz)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_merge
    assign merged[8*l +: 8] = s_lanes[l] ? s_wdata[8*l +: 8] : corr_word[8*l +: 8];
  end

  ecc_sram_enc enc_i (
    .data_i (merged),
    .code_o (enc_cw)
  );

  for (genvar p = 0; p < CW_W; p++) begin : g_fault
    assign fault_mask[p] = (s_pos == 5'(p));
  end

  assign wr_cw = (s_op == OP_FAULT) ? (cw_cur ^ fault_mask) : enc_cw;

  // Registered outputs
  logic             rd_live;
  logic [LANES-1:0] drv_d, drv_q;
  word_t            rdata_d, rdata_q;
  logic             flag_q, flag_drv_q;

  assign rd_live = (s_op == OP_READ);

  for (genvar l = 0; l < LANES; l++) begin : g_out
    assign drv_d[l]           = rd_live && s_lanes[l];
    assign rdata_d[8*l +: 8]  = drv_d[l] ? corr_word[8*l +: 8] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      drv_q      <= '0;
      rdata_q    <= '0;
      flag_q     <= 1'b0;
      flag_drv_q <= 1'b0;
    end else begin
      drv_q      <= drv_d;
      rdata_q    <= rdata_d;
      flag_q     <= rd_live && syn_nz;
      flag_drv_q <= rd_live;
    end
  end

  assign rdata     = rdata_q;
  assign hi_drv    = drv_q[1];
  assign lo_drv    = drv_q[0];
  assign corr_flag = flag_q;
  assign corr_drv  = flag_drv_q;
endmodule

// File: rtl/ecc_sram_core_chk.sv
module ecc_sram_core_chk (
  input logic        clk,
  input logic        rst,
  input logic        chip_sel_n,
  input logic        out_en_n,
  input logic        wr_n,
  input logic        hi_lane_n,
  input logic        lo_lane_n,
  input logic        inj_en,
  input logic [15:0] rdata,
  input logic        hi_drv,
  input logic        lo_drv,
  input logic        corr_flag,
  input logic        corr_drv
);
  logic quiet;
  assign quiet = !hi_drv && !lo_drv && !corr_drv && !corr_flag;

  AST_RST_QUIET: assert property (@(posedge clk) rst |=> quiet); // R1
  AST_FLAG_DRIVEN: assert property (@(posedge clk) disable iff (rst) corr_flag |-> corr_drv); // R8
  AST_FLAG_HAS_LANE: assert property (@(posedge clk) disable iff (rst) corr_drv |-> (hi_drv || lo_drv)); // R3
  AST_HI_ZERO: assert property (@(posedge clk) disable iff (rst) !hi_drv |-> (rdata[15:8] == 8'h00)); // R3
  AST_LO_ZERO: assert property (@(posedge clk) disable iff (rst) !lo_drv |-> (rdata[7:0] == 8'h00)); // R3
  AST_HI_LANE_OFF: assert property (@(posedge clk) disable iff (rst)
    (!chip_sel_n && wr_n && !out_en_n && hi_lane_n && !inj_en) |=> ##1 !hi_drv); // R3
  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (rst)
    (chip_sel_n && !inj_en) |=> ##1 quiet); // R5
  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!chip_sel_n && !wr_n && !inj_en) |=> ##1 quiet); // R6
  AST_OE_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!chip_sel_n && wr_n && out_en_n && !inj_en) |=> ##1 quiet); // R7
  AST_NO_LANE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!chip_sel_n && hi_lane_n && lo_lane_n && !inj_en) |=> ##1 quiet); // R7
  AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (rst)
    inj_en |=> ##1 quiet); // R12
endmodule

bind ecc_sram_core ecc_sram_core_chk chk_i (
  .clk        (clk),
  .rst        (rst),
  .chip_sel_n (chip_sel_n),
  .out_en_n   (out_en_n),
  .wr_n       (wr_n),
  .hi_lane_n  (hi_lane_n),
  .lo_lane_n  (lo_lane_n),
  .inj_en     (inj_en),
  .rdata      (rdata),
  .hi_drv     (hi_drv),
  .lo_drv     (lo_drv),
  .corr_flag  (corr_flag),
  .corr_drv   (corr_drv)
);

// File: tb/ecc_sram_core_tb_top.sv
`timescale 1ns/1ps
module ecc_sram_core_tb_top;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          chip_sel_n = 1'b1, out_en_n = 1'b1, wr_n = 1'b1;
  logic          hi_lane_n = 1'b1, lo_lane_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [15:0]   wdata = '0;
  logic          inj_en = 1'b0;
  logic [4:0]    inj_pos = '0;
  logic [15:0]   rdata;
  logic          hi_drv, lo_drv, corr_flag, corr_drv;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ecc_sram_core #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .chip_sel_n(chip_sel_n), .out_en_n(out_en_n), .wr_n(wr_n),
    .hi_lane_n(hi_lane_n), .lo_lane_n(lo_lane_n), .addr(addr), .wdata(wdata),
    .inj_en(inj_en), .inj_pos(inj_pos), .rdata(rdata), .hi_drv(hi_drv),
    .lo_drv(lo_drv), .corr_flag(corr_flag), .corr_drv(corr_drv)
  );

  // Reference model
  logic [15:0] mdl_data [16];
  bit          mdl_bad  [16];

  // Two-deep expectation pipeline
  bit          e_v  [2];
  bit          e_hd [2], e_ld [2], e_cd [2], e_cf [2];
  logic [15:0] e_q  [2];
  string       e_tag[2];

  task automatic compare_one(input int i);
    checks++;
    if (rdata !== e_q[i] || hi_drv !== e_hd[i] || lo_drv !== e_ld[i] ||
        corr_drv !== e_cd[i] || corr_flag !== e_cf[i]) begin
      errors++;
      $display("FAIL %s: got q=%h hd=%b ld=%b cd=%b cf=%b, expected q=%h hd=%b ld=%b cd=%b cf=%b",
               e_tag[i], rdata, hi_drv, lo_drv, corr_drv, corr_flag,
               e_q[i], e_hd[i], e_ld[i], e_cd[i], e_cf[i]);
    end
  endtask

  task automatic issue(input logic csn, input logic oen, input logic wn, input logic hn,
                       input logic ln, input int a, input logic [15:0] d,
                       input logic fe, input logic [4:0] fp, input string tag);
    @(negedge clk);
    if (e_v[1]) compare_one(1);
    e_v[1] = e_v[0]; e_hd[1] = e_hd[0]; e_ld[1] = e_ld[0];
    e_cd[1] = e_cd[0]; e_cf[1] = e_cf[0]; e_q[1] = e_q[0]; e_tag[1] = e_tag[0];
    chip_sel_n = csn; out_en_n = oen; wr_n = wn; hi_lane_n = hn; lo_lane_n = ln;
    addr = AW'(a); wdata = d; inj_en = fe; inj_pos = fp;
    e_v[0] = 1; e_hd[0] = 0; e_ld[0] = 0; e_cd[0] = 0; e_cf[0] = 0; e_q[0] = '0; e_tag[0] = tag;
    if (fe) begin
      if (fp < 5'd21) mdl_bad[a] = 1;
    end else if (!csn && !wn && (!hn || !ln)) begin
      if (!hn) mdl_data[a][15:8] = d[15:8];
      if (!ln) mdl_data[a][7:0]  = d[7:0];
      mdl_bad[a] = 0;
    end else if (!csn && wn && !oen && (!hn || !ln)) begin
      e_hd[0] = !hn; e_ld[0] = !ln; e_cd[0] = 1; e_cf[0] = mdl_bad[a];
      e_q[0] = {(!hn ? mdl_data[a][15:8] : 8'h00), (!ln ? mdl_data[a][7:0] : 8'h00)};
    end
  endtask

  task automatic wr(input int a, input logic [15:0] d, input string tag);
    issue(0, 1, 0, 0, 0, a, d, 0, 0, tag);
  endtask
  task automatic rd(input int a, input string tag);
    issue(0, 0, 1, 0, 0, a, 16'h0, 0, 0, tag);
  endtask
  task automatic idle(input string tag);
    issue(1, 1, 1, 1, 1, 0, 16'h0, 0, 0, tag);
  endtask
  task automatic inject(input int a, input logic [4:0] fp, input string tag);
    issue(1, 1, 1, 1, 1, a, 16'h0, 1, fp, tag);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7351));
    e_v[0] = 0; e_v[1] = 0;
    for (int i = 0; i < 16; i++) begin mdl_data[i] = '0; mdl_bad[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs quiet while in reset
    checks++;
    if (hi_drv || lo_drv || corr_drv || corr_flag || rdata != 16'h0) begin
      errors++;
      $display("FAIL R1: got q=%h hd=%b ld=%b cd=%b cf=%b, expected all zero",
               rdata, hi_drv, lo_drv, corr_drv, corr_flag);
    end
    rst = 1'b0;
    idle("R1"); idle("R1");

    // R2: fill and read back
    for (int i = 0; i < 16; i++) wr(i, 16'h1111 * i[15:0] ^ 16'hA55A, "R2");
    for (int i = 0; i < 4; i++) rd(i, "R2");
    // R3: single-lane reads
    issue(0, 0, 1, 0, 1, 1, 0, 0, 0, "R3");
    issue(0, 0, 1, 1, 0, 1, 0, 0, 0, "R3");
    // R4: single-lane writes
    issue(0, 1, 0, 0, 1, 2, 16'hBEEF, 0, 0, "R4");
    rd(2, "R4");
    issue(0, 1, 0, 1, 0, 2, 16'h1234, 0, 0, "R4");
    rd(2, "R4");
    // R5: deselected write does nothing
    issue(1, 0, 0, 0, 0, 3, 16'hDEAD, 0, 0, "R5");
    rd(3, "R5");
    // R6: write with output enable low
    issue(0, 0, 0, 0, 0, 4, 16'h0F0F, 0, 0, "R6");
    rd(4, "R6");
    // R7: no lanes / output enable high
    issue(0, 0, 1, 1, 1, 4, 0, 0, 0, "R7");
    issue(0, 1, 1, 0, 0, 4, 0, 0, 0, "R7");
    issue(0, 1, 0, 1, 1, 4, 16'h7777, 0, 0, "R7");
    rd(4, "R7");
    // R8: every codeword position
    for (int p = 0; p < 21; p++) begin
      wr(5, 16'hC3A5 ^ 16'(p * 16'h0101), "R8");
      inject(5, 5'(p), "R8");
      rd(5, "R8");
    end
    wr(5, 16'h5A5A, "R8");
    rd(5, "R8");
    // R9: no write-back
    inject(6, 5'd9, "R9");
    rd(6, "R9"); idle("R9"); rd(6, "R9");
    wr(6, 16'h6006, "R9");
    rd(6, "R9");
    // R10: single-lane write over a faulty word
    wr(7, 16'h1357, "R10");
    inject(7, 5'd2, "R10");
    issue(0, 1, 0, 0, 1, 7, 16'hAB00, 0, 0, "R10");
    rd(7, "R10");
    inject(7, 5'd12, "R10");
    issue(0, 1, 0, 1, 0, 7, 16'h00CD, 0, 0, "R10");
    rd(7, "R10");
    // R11: back-to-back same address
    wr(8, 16'h8888, "R11");
    rd(8, "R11");
    issue(0, 1, 0, 0, 1, 8, 16'h1200, 0, 0, "R11");
    issue(0, 1, 0, 1, 0, 8, 16'h0034, 0, 0, "R11");
    rd(8, "R11");
    inject(8, 5'd0, "R11");
    rd(8, "R11");
    // R12: bus ignored during injection; out-of-range index
    issue(0, 0, 0, 0, 0, 9, 16'hFFFF, 1, 5'd25, "R12");
    rd(9, "R12");
    inject(9, 5'd21, "R12");
    rd(9, "R12");
    inject(9, 5'd20, "R12");
    rd(9, "R12");

    // Random mix over a small address window
    for (int n = 0; n < 3000; n++) begin
      int a, k;
      logic h, l;
      a = $urandom_range(0, 7);
      k = $urandom_range(0, 11);
      h = 1'($urandom_range(0, 1));
      l = 1'($urandom_range(0, 1));
      case (k)
        0, 1, 2: issue(0, 0, 1, h, l, a, 0, 0, 0, mdl_bad[a] ? "R8" : "R2");
        3, 4:    wr(a, 16'($urandom), "R2");
        5, 6:    issue(0, 1, 0, h, !h, a, 16'($urandom), 0, 0, "R4");
        7:       issue(1, l, h, l, h, a, 16'($urandom), 0, 0, "R5");
        8:       issue(0, 1, 1, h, l, a, 0, 0, 0, "R7");
        9:       if (!mdl_bad[a]) inject(a, 5'($urandom_range(0, 20)), "R12");
                 else rd(a, "R9");
        10:      issue(0, l, 0, 1, 1, a, 16'($urandom), 0, 0, "R7");
        default: idle("R11");
      endcase
    end
    idle("R2"); idle("R2"); idle("R2");
    done = 1;
    summary();
    $finish;
  end
endmodule